// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the four word addresses of one burst access to a synchronous memory. A load strobe captures an external start address. That address is the first beat. An advance strobe then steps through three more beats. Each of these beats is derived from the start address inside the block.

Only the two least-significant bits change during a burst. The bits above them pass through untouched. A mode input, captured at load time, selects the order of the two low bits:

- Interleaved order forms each low-bit pair by XORing the start bits with the beat number.
- Linear order counts the low bits up modulo four from the start value.

A flag marks the fourth beat. A further advance after the fourth beat wraps back to the first beat.

Top module: `burst_seq_top`

## Requirements
- R1: While and after synchronous reset (rst high at a clock edge), addr_o is all zeros and last_o is 0.
- R2: In the cycle after a clock edge with load_i high, addr_o equals the addr_i sampled at that edge (beat 0).
- R3: When load_i and adv_i are both high at an edge, the load wins: addr_o shows the new addr_i and the burst is at beat 0.
- R4: With mode_i = 1 at load (interleaved), beat k (k = 0..3) shows low bits equal to start[1:0] XOR k.
- R5: With mode_i = 0 at load (linear), beat k shows low bits equal to (start[1:0] + k) mod 4.
- R6: addr_o bits above bit 1 keep the loaded value for the whole burst.
- R7: An edge with load_i and adv_i both low leaves addr_o and last_o unchanged.
- R8: An advance taken at beat 3 returns addr_o to the beat-0 address of the same burst.
- R9: last_o is 1 exactly while the burst is at beat 3.
- R10: A change of mode_i after the load edge has no effect on the order until the next load.
- R11: Across the four beats of a burst, each of the four low-bit values appears exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture addr_i and mode_i, restart at beat 0 |
| addr_i | input | ADDR_W | External start address |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Order select at load: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | High during beat 3 |

## Verification
The checker keeps its own copy of the start address, the captured mode and a beat count. It updates these only from load_i, adv_i and mode_i, so the properties assume those strobes are clean 0/1 values that are sampled at the rising edge.

The bench changes every input half a period away from the edge. It runs bursts from each of the four start values in both orders. It then adds directed cases that:
- combine load with advance,
- hold for several cycles without advancing,
- toggle mode in the middle of a burst,
- advance past the fourth beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  output logic [BEAT_W-1:0] beat,
  output logic              at_last
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)          beat <= '0;
    else if (restart) beat <= '0;
    else if (step)    beat <= beat + 1'b1;
  end

  assign at_last = (beat == LAST_BEAT);
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] lo_out
);
  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] lin_lo;

  function automatic logic [BEAT_W-1:0] wrap_add(input logic [BEAT_W-1:0] a,
                                                 input logic [BEAT_W-1:0] b);
    return a + b;
  endfunction

  genvar g;
  generate
    for (g = 0; g < BEAT_W; g++) begin : g_xor_bit
      assign xor_lo[g] = start_lo[g] ^ beat[g];
    end
  endgenerate

  assign lin_lo = wrap_add(start_lo, beat);

  always_comb begin
    case (order)
      ORD_INTERLEAVE: lo_out = xor_lo;
      default:        lo_out = lin_lo;
    endcase
  end
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  order_e            order_q;
  logic [BEAT_W-1:0] beat_w;
  logic [BEAT_W-1:0] lo_w;
  logic              load_evt;
  logic              step_evt;

  assign load_evt = load_i;
  assign step_evt = adv_i & ~load_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      order_q <= ORD_INTERLEAVE;
    end else if (load_evt) begin
      base_q  <= addr_i;
      order_q <= order_e'(mode_i);
    end
  end

  burst_beat_ctr #(.BEAT_W(BEAT_W)) ctr_i (
    .clk     (clk),
    .rst     (rst),
    .restart (load_evt),
    .step    (step_evt),
    .beat    (beat_w),
    .at_last (last_o)
  );

  burst_addr_map #(.BEAT_W(BEAT_W)) map_i (
    .start_lo (base_q[BEAT_W-1:0]),
    .beat     (beat_w),
    .order    (order_q),
    .lo_out   (lo_w)
  );

  assign addr_o = {base_q[ADDR_W-1 -: HI_W], lo_w};
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adv_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o
);
  localparam logic [BEAT_W-1:0] TOP_K = {BEAT_W{1'b1}};

  logic [ADDR_W-1:0] start_c;
  logic              mode_c;
  logic [BEAT_W-1:0] k_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_c <= '0;
      mode_c  <= 1'b1;
      k_c     <= '0;
    end else if (load_i) begin
      start_c <= addr_i;
      mode_c  <= mode_i;
      k_c     <= '0;
    end else if (adv_i) begin
      k_c <= k_c + 1'b1;
    end
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_o == $past(addr_i));

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && adv_i) |=> (!last_o && addr_o == $past(addr_i)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(last_o)));

  // R6
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  // R4 R10
  interleave_order_chk: assert property (@(posedge clk) disable iff (rst)
    mode_c |-> addr_o[BEAT_W-1:0] == (start_c[BEAT_W-1:0] ^ k_c));

  // R5 R10
  linear_order_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_c |-> addr_o[BEAT_W-1:0] == BEAT_W'(start_c[BEAT_W-1:0] + k_c));

  // R9
  last_flag_chk: assert property (@(posedge clk) disable iff (rst)
    last_o == (k_c == TOP_K));

  // R8
  wrap_home_chk: assert property (@(posedge clk) disable iff (rst)
    (last_o && adv_i && !load_i) |=> addr_o == start_c);
endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .load_i (load_i),
  .addr_i (addr_i),
  .adv_i  (adv_i),
  .mode_i (mode_i),
  .addr_o (addr_o),
  .last_o (last_o)
);

// File: tb/burst_seq_top_tb_top.sv
module burst_seq_top_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_i;
  logic [AW-1:0] addr_i;
  logic          adv_i;
  logic          mode_i;
  logic [AW-1:0] addr_o;
  logic          last_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  burst_seq_top #(.ADDR_W(AW), .BEAT_W(2)) dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .addr_i(addr_i),
    .adv_i(adv_i), .mode_i(mode_i), .addr_o(addr_o), .last_o(last_o)
  );

  // {mode, start[1:0], beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [8] = '{
    11'b1_00_00011011, 11'b1_01_01001110, 11'b1_10_10110001, 11'b1_11_11100100,
    11'b0_00_00011011, 11'b0_01_01101100, 11'b0_10_10110001, 11'b0_11_11000110
  };

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic m, input logic adv);
    load_i = 1'b1; addr_i = a; mode_i = m; adv_i = adv;
    cyc();
    load_i = 1'b0; adv_i = 1'b0;
  endtask

  task automatic do_adv();
    adv_i = 1'b1;
    cyc();
    adv_i = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] first;
    rst = 1'b1; load_i = 1'b0; addr_i = '0; adv_i = 1'b0; mode_i = 1'b1;
    repeat (3) cyc();
    // R1 reset state
    check("R1 addr", addr_o, '0);
    check("R1 last", {15'b0, last_o}, '0);
    rst = 1'b0;
    cyc();
    check("R1 after release", addr_o, '0);

    // table walk: R2 R4 R5 R6 R9 R11
    for (int i = 0; i < 8; i++) begin
      logic [3:0] seen;
      logic [AW-3:0] hi;
      hi = 14'(16'h1234 * (i + 1));
      seen = '0;
      do_load({hi, VEC[i][9:8]}, VEC[i][10], 1'b0);
      check("R2 load", addr_o, {hi, VEC[i][9:8]});
      for (int b = 0; b < 4; b++) begin
        logic [1:0] e;
        e = VEC[i][7 - 2*b -: 2];
        check(VEC[i][10] ? "R4 interleave" : "R5 linear", addr_o, {hi, e});
        check("R6 upper", {2'b0, addr_o[AW-1:2]}, {2'b0, hi});
        check("R9 last", {15'b0, last_o}, {15'b0, (b == 3)});
        seen[addr_o[1:0]] = 1'b1;
        do_adv();
      end
      check("R11 coverage", {12'b0, seen}, 16'h000f);
      // R8 wrap back to start
      check("R8 wrap", addr_o, {hi, VEC[i][9:8]});
    end

    // R7 hold without advance
    do_load(16'hABC1, 1'b1, 1'b0);
    do_adv();
    repeat (3) cyc();
    check("R7 hold", addr_o, 16'hABC0);
    check("R7 hold last", {15'b0, last_o}, '0);

    // R3 load with advance at beat 2
    do_adv();
    do_load(16'h5556, 1'b0, 1'b1);
    check("R3 load wins", addr_o, 16'h5556);
    check("R3 beat0", {15'b0, last_o}, '0);
    do_adv();
    check("R3 next beat", addr_o, 16'h5557);

    // R10 mode change mid burst ignored (linear from 01)
    do_load(16'h0F01, 1'b0, 1'b0);
    mode_i = 1'b1;
    do_adv();
    check("R10 mode ignored b1", addr_o, 16'h0F02);
    mode_i = 1'b0;
    do_adv();
    mode_i = 1'b1;
    do_adv();
    check("R10 mode ignored b3", addr_o, 16'h0F00);
    first = 16'h0F01;
    do_adv();
    check("R8 wrap linear", addr_o, first);

    // R1 reset mid burst
    do_adv();
    rst = 1'b1;
    cyc();
    check("R1 reset midburst", addr_o, '0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule